// File: doc/BRIEF.md
# Unit-Triangle Ray Hit Stage

This block is the back half of a two-step ray-triangle test. An earlier stage has already mapped each ray into a normalised space where the triangle under test has corners (1,0,0), (0,1,0) and (0,0,0), so its normal is (0,0,1). Given the mapped origin O' and direction D', the stage finds the ray parameter t, the barycentric pair u and v, and a hit decision. No edge or cross-product arithmetic is needed: there is one divide and two multiply-adds, and the cosine against the normal is simply D'z.

Triangles for one ray arrive one at a time. The first triangle carries a start flag and the final one carries an end flag. The stage keeps the nearest valid hit across that group. When the triangle marked as the end has been evaluated, it emits a single result record: a hit flag, t, u, v, the cosine and the triangle ID. All values are signed Q8.16 fixed point (24 bits, 16 fraction bits). The divide runs on a sequential restoring divider, and the stage refuses new input until the current triangle is finished.

Top module: `unit_tri_isect`

## Requirements
- R1: For a triangle with D'z nonzero, t equals (−O'z·65536)/D'z in Q8.16. The quotient is truncated toward zero, and its magnitude is clamped to 0x7FFFFF.
- R2: u = O'x + floor(t·D'x / 65536) and v = O'y + floor(t·D'y / 65536). These are reported as out_u and out_v for the kept hit.
- R3: A triangle counts as a hit only when all of these hold: u ≥ 0, v ≥ 0, u + v ≤ 65536 (1.0, edges included), t > EPS (default 16) and t strictly less than the best t held so far for the ray.
- R4: Across the triangles of one ray, the hit with the smallest t is kept. On a tie in t, the earlier triangle stays.
- R5: out_cos equals the D'z of the kept triangle, and out_id equals its in_id.
- R6: A triangle with D'z = 0 is a miss and starts no divide. in_ready returns high one cycle after acceptance. If the triangle is marked last, out_valid is high in the cycle after that.
- R7: For D'z nonzero, in_ready stays low for exactly 42 cycles after acceptance (40 divide steps plus 2). in_valid pulses while in_ready is low have no effect on the result.
- R8: in_first clears the best record before the triangle is compared. A triangle accepted with in_last makes out_valid pulse for one cycle with the record. With no hit, the record is out_hit = 0 and out_t = 0x7FFFFF. A triangle without in_last emits nothing.
- R9: While rst_n is low and just after its release, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Triangle offered |
| in_ready | output | 1 | Stage idle; offer accepted on this cycle |
| in_ox | input | 24 | Transformed origin x, Q8.16 |
| in_oy | input | 24 | Transformed origin y, Q8.16 |
| in_oz | input | 24 | Transformed origin z, Q8.16 |
| in_dx | input | 24 | Transformed direction x, Q8.16 |
| in_dy | input | 24 | Transformed direction y, Q8.16 |
| in_dz | input | 24 | Transformed direction z, Q8.16 |
| in_id | input | 8 | Triangle identifier |
| in_first | input | 1 | First triangle of a ray |
| in_last | input | 1 | Last triangle of a ray |
| out_valid | output | 1 | One-cycle result strobe |
| out_hit | output | 1 | A hit was found for the ray |
| out_t | output | 24 | Ray parameter of the kept hit |
| out_u | output | 24 | Barycentric u of the kept hit |
| out_v | output | 24 | Barycentric v of the kept hit |
| out_cos | output | 24 | Direction z of the kept hit (cosine term) |
| out_id | output | 8 | ID of the kept triangle |

## Verification
The assertions run on every cycle. They check that any reported hit lies inside the unit triangle and beyond EPS, and that a reported hit has a nonzero cosine. They also check that a miss reports the maximum t, that in_ready drops right after an acceptance, that a zero-direction triangle reports its miss two cycles after acceptance, and that out_valid never lasts longer than one cycle. Only the bench scenarios can show the numeric values against the formulas, including truncation and saturation. The same holds for the choice of the nearest hit and the earlier hit on a tie, the clearing by the start flag across rays, the exact 42-cycle busy window, and that offers made while busy are ignored.

// File: rtl/utri_pkg.sv
// Shared types for the unit-triangle hit stage.
package utri_pkg;
    // Control state of the stage sequencer.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DIV  = 2'd1,
        ST_EVAL = 2'd2
    } utri_state_e;
endpackage

// File: rtl/utri_divider.sv
// Sequential restoring divider on unsigned magnitudes.
// Computes (num_mag << FRAC) / den_mag, one quotient bit per cycle.
// Assumes den_mag is nonzero and that start only arrives while the divider is idle.
// done stays high for one cycle, W+FRAC cycles after start.
module utri_divider #(
    parameter int W    = 24,
    parameter int FRAC = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [W-1:0]  num_mag,
    input  logic [W-1:0]  den_mag,
    output logic          done,
    output logic [W+FRAC-1:0] quo
);
    localparam int DW = W + FRAC;
    localparam int CW = $clog2(DW + 1);

    logic          busy;
    logic [CW-1:0] cnt;
    logic [W-1:0]  rem;
    logic [DW-1:0] qr;
    logic [W-1:0]  den;
    logic [W:0]    rem_sh;
    logic [W:0]    diff;
    logic          ge;

    // Trial subtraction for the next quotient bit.
    always_comb begin
        rem_sh = {rem, qr[DW-1]};
        diff   = rem_sh - {1'b0, den};
        ge     = (rem_sh >= {1'b0, den});
    end

    // Load on start, then shift and subtract once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            rem  <= '0;
            qr   <= '0;
            den  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= CW'(DW);
            rem  <= '0;
            qr   <= {num_mag, {FRAC{1'b0}}};
            den  <= den_mag;
        end else if (busy) begin
            if (cnt != '0) begin
                rem <= ge ? diff[W-1:0] : rem_sh[W-1:0];
                qr  <= {qr[DW-2:0], ge};
                cnt <= cnt - 1'b1;
            end else begin
                busy <= 1'b0;
            end
        end
    end

    assign done = busy && (cnt == '0);
    assign quo  = qr;
endmodule

// File: rtl/utri_hit_eval.sv
// Combinational hit test in unit-triangle space.
// From t, the origin and the direction it forms u and v with two multiply-adds,
// then applies the inside, near-limit and closer-than-best tests.
// Assumes the Q8.16 signed format; intermediate sums are kept at double width.
module utri_hit_eval #(
    parameter int W    = 24,
    parameter int FRAC = 16,
    parameter int EPS  = 16
) (
    input  logic signed [W-1:0] t,
    input  logic signed [W-1:0] ox,
    input  logic signed [W-1:0] oy,
    input  logic signed [W-1:0] dx,
    input  logic signed [W-1:0] dy,
    input  logic signed [W-1:0] best_t,
    input  logic                force_miss,
    output logic                hit,
    output logic signed [W-1:0] u,
    output logic signed [W-1:0] v
);
    localparam int XW = 2 * W;
    localparam logic signed [XW-1:0] ONE_X = XW'(1) << FRAC;
    localparam logic signed [W-1:0]  EPS_T = W'(EPS);

    logic signed [XW-1:0] te, dxe, dye, oxe, oye;
    logic signed [XW-1:0] pu, pv, uw, vw, sw;

    // Sign-extend the operands and form u, v and u+v at double width.
    always_comb begin
        te  = {{W{t[W-1]}},  t};
        dxe = {{W{dx[W-1]}}, dx};
        dye = {{W{dy[W-1]}}, dy};
        oxe = {{W{ox[W-1]}}, ox};
        oye = {{W{oy[W-1]}}, oy};
        pu  = te * dxe;
        pv  = te * dye;
        uw  = oxe + (pu >>> FRAC);
        vw  = oye + (pv >>> FRAC);
        sw  = uw + vw;
    end

    // Hit decision from the five acceptance tests.
    always_comb begin
        hit = !force_miss && (uw >= 0) && (vw >= 0) && (sw <= ONE_X)
              && (t > EPS_T) && (t < best_t);
        u   = uw[W-1:0];
        v   = vw[W-1:0];
    end
endmodule

// File: rtl/utri_best_keep.sv
// Holds the nearest hit record of the current ray and emits it on the end flag.
// A start flag makes the comparison use an empty record (t at maximum).
// Assumes upd is high for exactly one cycle per evaluated triangle.
module utri_best_keep #(
    parameter int W   = 24,
    parameter int IDW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                upd,
    input  logic                first,
    input  logic                last,
    input  logic                hit,
    input  logic signed [W-1:0] t,
    input  logic signed [W-1:0] u,
    input  logic signed [W-1:0] v,
    input  logic signed [W-1:0] cosv,
    input  logic [IDW-1:0]      id,
    output logic signed [W-1:0] cmp_t,
    output logic                out_valid,
    output logic                out_hit,
    output logic signed [W-1:0] out_t,
    output logic signed [W-1:0] out_u,
    output logic signed [W-1:0] out_v,
    output logic signed [W-1:0] out_cos,
    output logic [IDW-1:0]      out_id
);
    localparam logic signed [W-1:0] TMAX = {1'b0, {(W-1){1'b1}}};

    logic                bh;
    logic signed [W-1:0] bt, bu, bv, bc;
    logic [IDW-1:0]      bi;
    logic                nh;
    logic signed [W-1:0] nt, nu, nv, nc;
    logic [IDW-1:0]      ni;

    // Comparison threshold: cleared record on a start flag.
    assign cmp_t = first ? TMAX : bt;

    // Next record: the new hit, else the (possibly cleared) held record.
    always_comb begin
        if (hit) begin
            nh = 1'b1; nt = t; nu = u; nv = v; nc = cosv; ni = id;
        end else if (first) begin
            nh = 1'b0; nt = TMAX; nu = '0; nv = '0; nc = '0; ni = '0;
        end else begin
            nh = bh; nt = bt; nu = bu; nv = bv; nc = bc; ni = bi;
        end
    end

    // Store the record and strobe it out on the end flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bh <= 1'b0; bt <= TMAX; bu <= '0; bv <= '0; bc <= '0; bi <= '0;
            out_valid <= 1'b0; out_hit <= 1'b0; out_t <= '0; out_u <= '0;
            out_v <= '0; out_cos <= '0; out_id <= '0;
        end else begin
            out_valid <= 1'b0;
            if (upd) begin
                bh <= nh; bt <= nt; bu <= nu; bv <= nv; bc <= nc; bi <= ni;
                if (last) begin
                    out_valid <= 1'b1;
                    out_hit   <= nh;
                    out_t     <= nt;
                    out_u     <= nu;
                    out_v     <= nv;
                    out_cos   <= nc;
                    out_id    <= ni;
                end
            end
        end
    end
endmodule

// File: rtl/unit_tri_isect.sv
// Unit-triangle ray hit stage, top level.
// Accepts one transformed triangle at a time. It divides for t (skipped when
// the z direction is zero), evaluates the hit in one cycle and folds the
// result into the per-ray nearest record.
// Assumes Q8.16 signed operands; in_ready low means offers are ignored.
module unit_tri_isect #(
    parameter int W    = 24,
    parameter int FRAC = 16,
    parameter int IDW  = 8,
    parameter int EPS  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic signed [W-1:0] in_ox,
    input  logic signed [W-1:0] in_oy,
    input  logic signed [W-1:0] in_oz,
    input  logic signed [W-1:0] in_dx,
    input  logic signed [W-1:0] in_dy,
    input  logic signed [W-1:0] in_dz,
    input  logic [IDW-1:0]      in_id,
    input  logic                in_first,
    input  logic                in_last,
    output logic                out_valid,
    output logic                out_hit,
    output logic signed [W-1:0] out_t,
    output logic signed [W-1:0] out_u,
    output logic signed [W-1:0] out_v,
    output logic signed [W-1:0] out_cos,
    output logic [IDW-1:0]      out_id
);
    import utri_pkg::*;

    localparam int DW = W + FRAC;
    localparam logic [DW-1:0] TMAX_Q = {{(DW-W+1){1'b0}}, {(W-1){1'b1}}};

    utri_state_e         state;
    logic                acc, zero_dz, div_start, div_done, q_neg;
    logic signed [W:0]   nw, dw;
    logic [W-1:0]        n_mag, d_mag, t_mag;
    logic [DW-1:0]       quo;
    logic signed [W-1:0] lx, ly, ldx, ldy, ldz, t_q, cmp_t, ev_u, ev_v;
    logic [IDW-1:0]      lid;
    logic                lfirst, llast, lneg, lzero, ev_hit;

    assign in_ready  = (state == ST_IDLE);
    assign acc       = in_valid && in_ready;
    assign zero_dz   = (in_dz == '0);
    assign div_start = acc && !zero_dz;

    // Magnitudes and quotient sign of (-oz)/dz.
    always_comb begin
        nw    = -{in_oz[W-1], in_oz};
        dw    = {in_dz[W-1], in_dz};
        n_mag = nw[W] ? W'(-nw) : nw[W-1:0];
        d_mag = dw[W] ? W'(-dw) : dw[W-1:0];
        q_neg = nw[W] ^ dw[W];
        t_mag = (quo > TMAX_Q) ? TMAX_Q[W-1:0] : quo[W-1:0];
    end

    utri_divider #(.W(W), .FRAC(FRAC)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start),
        .num_mag(n_mag), .den_mag(d_mag), .done(div_done), .quo(quo)
    );

    // Sequencer: latch the triangle, wait for the divide, evaluate once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            lx <= '0; ly <= '0; ldx <= '0; ldy <= '0; ldz <= '0; lid <= '0;
            lfirst <= 1'b0; llast <= 1'b0; lneg <= 1'b0; lzero <= 1'b0;
            t_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (acc) begin
                    lx <= in_ox; ly <= in_oy; ldx <= in_dx; ldy <= in_dy;
                    ldz <= in_dz; lid <= in_id; lfirst <= in_first;
                    llast <= in_last; lneg <= q_neg; lzero <= zero_dz;
                    t_q <= '0;
                    state <= zero_dz ? ST_EVAL : ST_DIV;
                end
                ST_DIV: if (div_done) begin
                    t_q   <= lneg ? -$signed(t_mag) : $signed(t_mag);
                    state <= ST_EVAL;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    utri_hit_eval #(.W(W), .FRAC(FRAC), .EPS(EPS)) u_eval (
        .t(t_q), .ox(lx), .oy(ly), .dx(ldx), .dy(ldy), .best_t(cmp_t),
        .force_miss(lzero), .hit(ev_hit), .u(ev_u), .v(ev_v)
    );

    utri_best_keep #(.W(W), .IDW(IDW)) u_keep (
        .clk(clk), .rst_n(rst_n), .upd(state == ST_EVAL), .first(lfirst),
        .last(llast), .hit(ev_hit), .t(t_q), .u(ev_u), .v(ev_v), .cosv(ldz),
        .id(lid), .cmp_t(cmp_t), .out_valid(out_valid), .out_hit(out_hit),
        .out_t(out_t), .out_u(out_u), .out_v(out_v), .out_cos(out_cos),
        .out_id(out_id)
    );
endmodule

// File: rtl/utri_chk.sv
// Protocol and result checker for unit_tri_isect, attached with bind.
// Assumes the default Q8.16 format; it only observes ports.
module utri_chk #(
    parameter int W    = 24,
    parameter int FRAC = 16,
    parameter int EPS  = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_ready,
    input logic signed [W-1:0] in_dz,
    input logic                in_last,
    input logic                out_valid,
    input logic                out_hit,
    input logic signed [W-1:0] out_t,
    input logic signed [W-1:0] out_u,
    input logic signed [W-1:0] out_v,
    input logic signed [W-1:0] out_cos
);
    localparam logic signed [W:0]   ONE_C = (W+1)'(1) << FRAC;
    localparam logic signed [W-1:0] TMAX  = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] EPS_C = W'(EPS);

    // R3
    hit_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_hit |-> (out_u >= 0) && (out_v >= 0)
            && (({out_u[W-1], out_u} + {out_v[W-1], out_v}) <= ONE_C)
            && (out_t > EPS_C) && (out_t < TMAX));

    // R5
    hit_cos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_hit |-> (out_cos != '0));

    // R8
    miss_tmax_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_hit |-> (out_t == TMAX));

    // R8
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R7
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> !in_ready);

    // R6
    zero_dz_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && (in_dz == '0) && in_last |=> ##1 (out_valid && !out_hit));
endmodule

bind unit_tri_isect utri_chk #(.W(W), .FRAC(FRAC), .EPS(EPS)) u_chk (.*);

// File: tb/tb_unit_tri_isect.sv
// Self-checking bench: a vector table of single-triangle rays, then directed cases.
module tb_unit_tri_isect;
    localparam int  W = 24;
    localparam int  IDW = 8;
    localparam int  ONE = 65536;
    localparam longint TMAX = 64'd8388607;
    localparam int  NV = 10;
    // ox, oy, oz, dx, dy, dz, expected hit
    localparam int VT [NV][7] = '{
        '{16384, 16384, 65536, 0, 0, -65536, 1},
        '{-32768, 16384, 65536, 0, 0, -65536, 0},
        '{49152, 32768, 131072, 0, 0, -65536, 0},
        '{13107, 13107, -65536, 0, 0, -65536, 0},
        '{0, 0, 131072, 8192, 16384, -65536, 1},
        '{32768, 32768, 65536, 0, 0, -65536, 1},
        '{6554, 6554, -196608, 0, 0, 98304, 1},
        '{19661, 19661, 65536, 0, 0, -196608, 1},
        '{13107, 13107, 8, 0, 0, -65536, 0},
        '{13107, 13107, 4194304, 0, 0, -1, 0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
    logic in_ready;
    logic signed [W-1:0] in_ox = '0, in_oy = '0, in_oz = '0, in_dx = '0, in_dy = '0, in_dz = '0;
    logic [IDW-1:0] in_id = '0;
    logic out_valid, out_hit;
    logic signed [W-1:0] out_t, out_u, out_v, out_cos;
    logic [IDW-1:0] out_id;

    int checks = 0, errors = 0;
    logic got;

    always #2 clk = ~clk;

    unit_tri_isect dut (.*);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input int ox, oy, oz, dx, dy, dz, input int id, input bit f, l);
        while (!in_ready) @(negedge clk);
        in_ox = W'(ox); in_oy = W'(oy); in_oz = W'(oz);
        in_dx = W'(dx); in_dy = W'(dy); in_dz = W'(dz);
        in_id = IDW'(id); in_first = f; in_last = l; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_out();
        int n = 0;
        got = 1'b0;
        while (!out_valid && n < 300) begin
            @(negedge clk);
            n++;
        end
        got = out_valid;
    endtask

    function automatic longint model_t(input int oz, input int dz);
        longint q = (-longint'(oz) * 65536) / longint'(dz);
        if (q > TMAX) q = TMAX;
        if (q < -TMAX) q = -TMAX;
        return q;
    endfunction

    function automatic longint model_uv(input int o, input int d, input longint t);
        return longint'(o) + ((t * longint'(d)) >>> 16);
    endfunction

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
        $finish;
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(out_valid == 1'b0, "R9 out_valid in reset", out_valid, 0);
        chk(in_ready == 1'b1, "R9 in_ready in reset", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R9 after release", {out_valid, in_ready}, 1);

        // R1 R2 R3 R5 table of single-triangle rays
        for (int i = 0; i < NV; i++) begin
            longint t, u, v;
            bit eh;
            t = model_t(VT[i][2], VT[i][5]);
            u = model_uv(VT[i][0], VT[i][3], t);
            v = model_uv(VT[i][1], VT[i][4], t);
            eh = (u >= 0) && (v >= 0) && (u + v <= ONE) && (t > 16) && (t < TMAX);
            chk(eh == bit'(VT[i][6]), "R3 model vs table", eh, VT[i][6]);
            send(VT[i][0], VT[i][1], VT[i][2], VT[i][3], VT[i][4], VT[i][5], i + 10, 1'b1, 1'b1);
            wait_out();
            chk(got == 1'b1, "R8 strobe per ray", got, 1);
            chk(out_hit == eh, "R3 hit flag", out_hit, eh);
            if (eh) begin
                chk(longint'(out_t) == t, "R1 t value", out_t, t);
                chk(longint'(out_u) == u, "R2 u value", out_u, u);
                chk(longint'(out_v) == v, "R2 v value", out_v, v);
                chk(longint'(out_cos) == VT[i][5], "R5 cosine", out_cos, VT[i][5]);
                chk(out_id == IDW'(i + 10), "R5 id", out_id, i + 10);
            end else begin
                chk(longint'(out_t) == TMAX, "R8 miss t max", out_t, TMAX);
            end
        end

        // R4 nearest of three kept
        send(16384, 16384, 131072, 0, 0, -65536, 1, 1'b1, 1'b0);
        send(16384, 16384, 65536, 0, 0, -65536, 2, 1'b0, 1'b0);
        send(16384, 16384, 98304, 0, 0, -65536, 3, 1'b0, 1'b1);
        wait_out();
        chk(got && out_hit && out_id == 8'd2, "R4 nearest id", out_id, 2);
        chk(longint'(out_t) == 65536, "R4 nearest t", out_t, 65536);

        // R4 tie keeps earlier triangle
        send(16384, 16384, 65536, 0, 0, -65536, 4, 1'b1, 1'b0);
        send(32768, 16384, 65536, 0, 0, -65536, 5, 1'b0, 1'b1);
        wait_out();
        chk(got && out_id == 8'd4, "R4 tie id", out_id, 4);
        chk(longint'(out_u) == 16384, "R4 tie u", out_u, 16384);

        // R8 start flag clears previous ray's hit
        send(-32768, 0, 65536, 0, 0, -65536, 6, 1'b1, 1'b1);
        wait_out();
        chk(got && !out_hit, "R8 cleared by first", out_hit, 0);

        // R8 no strobe without last, then record carried to last
        send(16384, 16384, 65536, 0, 0, -65536, 7, 1'b1, 1'b0);
        cnt = 0;
        while (!in_ready) begin
            if (out_valid) cnt++;
            @(negedge clk);
        end
        repeat (3) begin
            if (out_valid) cnt++;
            @(negedge clk);
        end
        chk(cnt == 0, "R8 no strobe without last", cnt, 0);
        send(-32768, 0, 65536, 0, 0, -65536, 8, 1'b0, 1'b1);
        wait_out();
        chk(got && out_hit && out_id == 8'd7, "R8 held record emitted", out_id, 7);

        // R6 zero direction: quick miss
        send(16384, 16384, 65536, 0, 0, 0, 9, 1'b1, 1'b1);
        chk(in_ready == 1'b0, "R6 busy one cycle", in_ready, 0);
        @(negedge clk);
        chk(in_ready == 1'b1, "R6 ready after one cycle", in_ready, 1);
        chk(out_valid && !out_hit, "R6 miss strobe timing", {out_valid, out_hit}, 2);

        // R7 busy window and offers ignored while busy
        send(-32768, 16384, 65536, 0, 0, -65536, 11, 1'b1, 1'b1);
        cnt = 0;
        in_ox = W'(16384); in_oy = W'(16384); in_id = 8'd12; in_valid = 1'b1;
        repeat (5) begin
            if (!in_ready) cnt++;
            @(negedge clk);
        end
        in_valid = 1'b0;
        while (!in_ready && cnt < 200) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == 42, "R7 busy cycles", cnt, 42);
        wait_out();
        chk(got && !out_hit, "R7 offer while busy ignored", out_hit, 0);
        repeat (60) @(negedge clk);
        chk(out_valid == 1'b0, "R7 no later strobe", out_valid, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule